// File: doc/BRIEF.md
# Parallel Printer Port Control Register

This block holds the host-programmable control byte of a PC-style parallel printer port. Four of its bits drive the printer handshake lines, each with its own fixed polarity. One bit chooses whether the data lines face outward or inward, and that choice takes effect only while the port runs in its extended mode. One bit lets a rising edge on the printer's acknowledge line raise an interrupt to the host.

The host reaches the block through a small synchronous register bus. It carries an address offset, write and read enables, and separate write and read data bytes. Read data is combinational from the stored state, so it is valid in the same cycle as the read enable.

A second offset acts as a status window. Reading it returns the pending-interrupt flag and the synchronized acknowledge level. In held-interrupt builds, that read also clears the interrupt.

Top module: `lpt_ctrl_reg`

## Requirements
- R1: The `nStrobe` pin always shows the inverse of control bit 0.
- R2: The `nAutoFd` pin always shows the inverse of control bit 1. Setting the bit asks the printer to feed a line after every line.
- R3: The `nInit` pin always shows control bit 2 without inversion.
- R4: The `nSlctIn` pin always shows the inverse of control bit 3. Setting the bit selects the printer.
- R5: After reset the control byte is 0x00. The pins then sit at `nStrobe`=1, `nAutoFd`=1, `nInit`=0 and `nSlctIn`=1, with `dirIn`=0 and `irq`=0.
- R6: `dirIn` equals control bit 5 only while `extMode` is 1. A value of 1 means the data lines are inputs. While `extMode` is 0, `dirIn` is 0 whatever bit 5 holds.
- R7: Reading at offset `CTRL_OFFSET` (default 2) returns control bits 5..0 as last written. Bits 7 and 6 always read 0, and writes to them are dropped.
- R8: While control bit 4 is 0, `irq` stays 0 regardless of `nAck` activity.
- R9: With control bit 4 set, a low-to-high change on `nAck` passes through a two-flop synchronizer and an edge detector. `irq` goes high after the third rising clock edge that sees `nAck` high, and is still low after the second.
- R10: When `IRQ_HOLD`=1, `irq` stays high until a read at offset `STAT_OFFSET` (default 1). That read returns bit 2 = pending interrupt and bit 6 = synchronized `nAck` level. `irq` drops after the clock edge that ends the read.
- R11: When `IRQ_HOLD`=0, each qualifying `nAck` rise gives an `irq` pulse exactly one clock cycle long.
- R12: A high-to-low change on `nAck` never raises `irq`.
- R13: Offsets other than the control and status offsets read 0. Writes to them leave the control byte unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| extMode | input | 1 | 1 = extended (bidirectional) mode, 0 = printer-compatible mode |
| addr | input | ADDR_W | Register offset |
| wrEn | input | 1 | Write enable |
| rdEn | input | 1 | Read enable |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data, combinational |
| nAck | input | 1 | Printer acknowledge input, asynchronous |
| nStrobe | output | 1 | Strobe pin, active low |
| nAutoFd | output | 1 | Auto line-feed pin, active low |
| nInit | output | 1 | Initialise pin |
| nSlctIn | output | 1 | Printer-select pin, active low |
| dirIn | output | 1 | Data direction, 1 = input |
| irq | output | 1 | Interrupt request to the host |

## Verification
Control writes reach the pins and `dirIn` one register stage later, so the bench checks them half a cycle after the capturing edge. Read data and the mode gating of `dirIn` are combinational, so the bench checks them within the same cycle, shortly after driving.

The interrupt path is three register stages deep. The bench samples `irq` after the second edge that follows a rising `nAck` and expects it low. It samples again after the third edge and expects it high. The pulse variant is then expected low one cycle later, and the held variant after the edge that ends the status read.

// File: rtl/lpt_ctrl_pkg.sv
package lpt_ctrl_pkg;

  // Control bit positions; the pin mapping depends on them.
  localparam int CB_STROBE = 0;
  localparam int CB_AUTOFD = 1;
  localparam int CB_INIT   = 2;
  localparam int CB_SELECT = 3;
  localparam int CB_IRQEN  = 4;
  localparam int CB_DIR    = 5;
  localparam int CTRL_W    = 6;

  // Status word bit positions.
  localparam int SB_PEND   = 2;
  localparam int SB_ACK    = 6;

  typedef struct packed {
    logic ctrlWr;   // write to control offset
    logic ctrlRd;   // read of control offset
    logic statRd;   // read of status offset
    logic ackRise;  // synchronized rising edge of nAck
    logic ackLvl;   // synchronized nAck level
  } lptStrobes_t;

endpackage

// File: rtl/lpt_ctrl_ctl.sv
module lpt_ctrl_ctl
  import lpt_ctrl_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int CTRL_OFFSET = 2,
  parameter int STAT_OFFSET = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              nAck,
  output lptStrobes_t       strb
);

  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(CTRL_OFFSET);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(STAT_OFFSET);

  logic ctrlHit;
  logic statHit;
  logic [SYNC_STAGES-1:0] syncQ;
  logic ackPrev;

  assign ctrlHit = (addr == CTRL_ADDR);
  assign statHit = (addr == STAT_ADDR);

  // Synchronizer chain, idle level is high
  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) syncQ[0] <= 1'b1;
          else       syncQ[0] <= nAck;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rstN) syncQ[gi] <= 1'b1;
          else       syncQ[gi] <= syncQ[gi-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) ackPrev <= 1'b1;
    else       ackPrev <= syncQ[SYNC_STAGES-1];
  end

  always_comb begin
    strb.ctrlWr  = wrEn & ctrlHit;
    strb.ctrlRd  = rdEn & ctrlHit;
    strb.statRd  = rdEn & statHit;
    strb.ackLvl  = syncQ[SYNC_STAGES-1];
    strb.ackRise = syncQ[SYNC_STAGES-1] & ~ackPrev;
  end

endmodule

// File: rtl/lpt_ctrl_dp.sv
module lpt_ctrl_dp
  import lpt_ctrl_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter bit IRQ_HOLD = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              extMode,
  input  lptStrobes_t       strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] ctrlQ,
  output logic              nStrobe,
  output logic              nAutoFd,
  output logic              nInit,
  output logic              nSlctIn,
  output logic              dirIn,
  output logic              irq
);

  localparam logic [DATA_W-1:0] WR_MASK = DATA_W'((1 << CTRL_W) - 1);

  logic irqEn;
  logic irqFlag;
  logic [DATA_W-1:0] statWord;

  // Control byte, upper bits masked off so they stay zero
  always_ff @(posedge clk) begin
    if (!rstN)            ctrlQ <= '0;
    else if (strb.ctrlWr) ctrlQ <= wrData & WR_MASK;
  end

  assign irqEn = ctrlQ[CB_IRQEN];

  // Pin drive, fixed polarity per bit
  always_comb begin
    nStrobe = ~ctrlQ[CB_STROBE];
    nAutoFd = ~ctrlQ[CB_AUTOFD];
    nInit   =  ctrlQ[CB_INIT];
    nSlctIn = ~ctrlQ[CB_SELECT];
    dirIn   =  extMode & ctrlQ[CB_DIR];
  end

  // Interrupt variant chosen by parameter
  generate
    if (IRQ_HOLD) begin : g_held
      always_ff @(posedge clk) begin
        if (!rstN)                        irqFlag <= 1'b0;
        else if (strb.ackRise && irqEn)   irqFlag <= 1'b1;
        else if (strb.statRd)             irqFlag <= 1'b0;
      end
    end else begin : g_pulse
      always_ff @(posedge clk) begin
        if (!rstN) irqFlag <= 1'b0;
        else       irqFlag <= strb.ackRise & irqEn;
      end
    end
  endgenerate

  assign irq = irqFlag & irqEn;

  always_comb begin
    statWord         = '0;
    statWord[SB_PEND] = irq;
    statWord[SB_ACK]  = strb.ackLvl;
  end

  always_comb begin
    if (strb.ctrlRd)      rdData = ctrlQ;
    else if (strb.statRd) rdData = statWord;
    else                  rdData = '0;
  end

endmodule

// File: rtl/lpt_ctrl_reg.sv
module lpt_ctrl_reg
  import lpt_ctrl_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 8,
  parameter int CTRL_OFFSET = 2,
  parameter int STAT_OFFSET = 1,
  parameter int SYNC_STAGES = 2,
  parameter bit IRQ_HOLD    = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              extMode,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              nAck,
  output logic              nStrobe,
  output logic              nAutoFd,
  output logic              nInit,
  output logic              nSlctIn,
  output logic              dirIn,
  output logic              irq
);

  lptStrobes_t       strb;
  logic [DATA_W-1:0] ctrlQ;

  lpt_ctrl_ctl #(
    .ADDR_W(ADDR_W), .CTRL_OFFSET(CTRL_OFFSET),
    .STAT_OFFSET(STAT_OFFSET), .SYNC_STAGES(SYNC_STAGES)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn),
    .rdEn(rdEn), .nAck(nAck), .strb(strb)
  );

  lpt_ctrl_dp #(.DATA_W(DATA_W), .IRQ_HOLD(IRQ_HOLD)) u_dp (
    .clk(clk), .rstN(rstN), .extMode(extMode), .strb(strb),
    .wrData(wrData), .rdData(rdData), .ctrlQ(ctrlQ),
    .nStrobe(nStrobe), .nAutoFd(nAutoFd), .nInit(nInit),
    .nSlctIn(nSlctIn), .dirIn(dirIn), .irq(irq)
  );

endmodule

// File: rtl/lpt_ctrl_chk.sv
module lpt_ctrl_chk #(
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 8,
  parameter int CTRL_OFFSET = 2,
  parameter int STAT_OFFSET = 1,
  parameter bit IRQ_HOLD    = 1'b1
) (
  input logic              clk,
  input logic              rstN,
  input logic              extMode,
  input logic [ADDR_W-1:0] addr,
  input logic              wrEn,
  input logic              rdEn,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic              nStrobe,
  input logic              nInit,
  input logic              dirIn,
  input logic              irq,
  input logic [DATA_W-1:0] ctrlQ
);

  localparam logic [ADDR_W-1:0] CA = ADDR_W'(CTRL_OFFSET);
  localparam logic [ADDR_W-1:0] SA = ADDR_W'(STAT_OFFSET);

  assert_strobe_follows_R1: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == CA) |=> (nStrobe == !$past(wrData[0])));

  assert_init_follows_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == CA) |=> (nInit == $past(wrData[2])));

  assert_dir_gated_R6: assert property (@(posedge clk) disable iff (!rstN)
    !extMode |-> !dirIn);

  assert_high_bits_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == CA) |-> (rdData[DATA_W-1 -: 2] == 2'b00));

  assert_irq_needs_enable_R8: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlQ[4] |-> !irq);

  generate
    if (IRQ_HOLD) begin : g_held
      assert_irq_held_R10: assert property (@(posedge clk) disable iff (!rstN)
        (irq && !(rdEn && addr == SA) && !(wrEn && addr == CA)) |=> irq);
    end else begin : g_pulse
      assert_irq_one_cycle_R11: assert property (@(posedge clk) disable iff (!rstN)
        irq |=> !irq);
    end
  endgenerate

endmodule

bind lpt_ctrl_reg lpt_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_OFFSET(CTRL_OFFSET),
  .STAT_OFFSET(STAT_OFFSET), .IRQ_HOLD(IRQ_HOLD)
) u_chk (
  .clk(clk), .rstN(rstN), .extMode(extMode), .addr(addr), .wrEn(wrEn),
  .rdEn(rdEn), .wrData(wrData), .rdData(rdData), .nStrobe(nStrobe),
  .nInit(nInit), .dirIn(dirIn), .irq(irq), .ctrlQ(ctrlQ)
);

// File: tb/lpt_ctrl_reg_tb.sv
module lpt_ctrl_reg_tb;

  localparam int AW = 3;
  localparam int DW = 8;
  localparam logic [AW-1:0] CA = 3'd2;
  localparam logic [AW-1:0] SA = 3'd1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic extMode = 1'b0;
  logic [AW-1:0] addr = '0;
  logic wrEn = 1'b0;
  logic rdEn = 1'b0;
  logic [DW-1:0] wrData = '0;
  logic nAck = 1'b1;

  logic [DW-1:0] rdData, rdDataP;
  logic nStrobe, nAutoFd, nInit, nSlctIn, dirIn, irq;
  logic pStb, pAfd, pIni, pSel, pDir, irqP;

  int nChecks = 0;
  int nFails = 0;

  always #4 clk = ~clk;

  lpt_ctrl_reg #(.IRQ_HOLD(1'b1)) u_dut (
    .clk(clk), .rstN(rstN), .extMode(extMode), .addr(addr), .wrEn(wrEn),
    .rdEn(rdEn), .wrData(wrData), .rdData(rdData), .nAck(nAck),
    .nStrobe(nStrobe), .nAutoFd(nAutoFd), .nInit(nInit),
    .nSlctIn(nSlctIn), .dirIn(dirIn), .irq(irq)
  );

  lpt_ctrl_reg #(.IRQ_HOLD(1'b0)) u_dut_pulse (
    .clk(clk), .rstN(rstN), .extMode(extMode), .addr(addr), .wrEn(wrEn),
    .rdEn(rdEn), .wrData(wrData), .rdData(rdDataP), .nAck(nAck),
    .nStrobe(pStb), .nAutoFd(pAfd), .nInit(pIni),
    .nSlctIn(pSel), .dirIn(pDir), .irq(irqP)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // Read data is combinational; returns value and ends the read at next negedge.
  task automatic busRead(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    #1 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic testReset;
    logic [DW-1:0] d;
    check(nStrobe == 1'b1, "R5 nStrobe", nStrobe, 1);
    check(nAutoFd == 1'b1, "R5 nAutoFd", nAutoFd, 1);
    check(nInit   == 1'b0, "R5 nInit", nInit, 0);
    check(nSlctIn == 1'b1, "R5 nSlctIn", nSlctIn, 1);
    check(dirIn == 1'b0 && irq == 1'b0, "R5 dir/irq", {dirIn, irq}, 0);
    busRead(CA, d);
    check(d == 8'h00, "R5 control readback", d, 0);
  endtask

  task automatic testPins;
    logic [3:0] pat [4] = '{4'b0001, 4'b0010, 4'b0100, 4'b1011};
    for (int i = 0; i < 4; i++) begin
      busWrite(CA, {4'b0000, pat[i]});
      check(nStrobe == ~pat[i][0], "R1 nStrobe", nStrobe, ~pat[i][0]);
      check(nAutoFd == ~pat[i][1], "R2 nAutoFd", nAutoFd, ~pat[i][1]);
      check(nInit   ==  pat[i][2], "R3 nInit", nInit, pat[i][2]);
      check(nSlctIn == ~pat[i][3], "R4 nSlctIn", nSlctIn, ~pat[i][3]);
    end
  endtask

  task automatic testReadback;
    logic [DW-1:0] d;
    busWrite(CA, 8'hFF);
    busRead(CA, d);
    check(d == 8'h3F, "R7 upper bits dropped", d, 8'h3F);
    busWrite(CA, 8'hA5);
    busRead(CA, d);
    check(d == 8'h25, "R7 readback", d, 8'h25);
  endtask

  task automatic testOtherAddr;
    logic [DW-1:0] d;
    busWrite(CA, 8'h0A);
    busWrite(3'd5, 8'h35);
    busWrite(3'd0, 8'h15);
    busRead(CA, d);
    check(d == 8'h0A, "R13 other-offset write ignored", d, 8'h0A);
    check(nStrobe == 1'b1 && nInit == 1'b0, "R13 pins unchanged", {nStrobe, nInit}, 2'b10);
    busRead(3'd6, d);
    check(d == 8'h00, "R13 unmapped read", d, 0);
  endtask

  task automatic testDir;
    extMode = 1'b0;
    busWrite(CA, 8'h20);
    check(dirIn == 1'b0, "R6 printer mode forces output", dirIn, 0);
    @(negedge clk); extMode = 1'b1; #1;
    check(dirIn == 1'b1, "R6 extended mode input", dirIn, 1);
    busWrite(CA, 8'h00);
    check(dirIn == 1'b0, "R6 extended mode output", dirIn, 0);
    extMode = 1'b0;
  endtask

  task automatic ackRiseAndWait(input int edges);
    @(negedge clk); nAck = 1'b0;
    repeat (4) @(negedge clk);
    nAck = 1'b1;
    repeat (edges) @(posedge clk);
    #1;
  endtask

  task automatic testIrqDisabled;
    busWrite(CA, 8'h00);
    ackRiseAndWait(6);
    check(irq == 1'b0 && irqP == 1'b0, "R8 disabled irq stays low", {irq, irqP}, 0);
  endtask

  task automatic testIrqTiming;
    logic [DW-1:0] d;
    busWrite(CA, 8'h10);
    ackRiseAndWait(2);
    check(irq == 1'b0 && irqP == 1'b0, "R9 low after second edge", {irq, irqP}, 0);
    @(posedge clk); #1;
    check(irq == 1'b1, "R9 held irq after third edge", irq, 1);
    check(irqP == 1'b1, "R9 pulse irq after third edge", irqP, 1);
    @(posedge clk); #1;
    check(irqP == 1'b0, "R11 pulse one cycle", irqP, 0);
    check(irq == 1'b1, "R10 held irq stays", irq, 1);
    repeat (3) @(posedge clk); #1;
    check(irq == 1'b1, "R10 held irq still high", irq, 1);
    busRead(SA, d);
    check(d[2] == 1'b1 && d[6] == 1'b1, "R10 status word", d, 8'h44);
    check(irq == 1'b0, "R10 cleared by status read", irq, 0);
  endtask

  task automatic testFallIgnored;
    busWrite(CA, 8'h10);
    @(negedge clk); nAck = 1'b0;
    repeat (6) @(posedge clk); #1;
    check(irq == 1'b0 && irqP == 1'b0, "R12 falling nAck ignored", {irq, irqP}, 0);
    nAck = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    begin
      logic [DW-1:0] d;
      busRead(SA, d);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    testReset();
    testPins();
    testReadback();
    testOtherAddr();
    testDir();
    testIrqDisabled();
    testIrqTiming();
    testFallIgnored();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule